// File: doc/BRIEF.md
# Instruction Breakpoint Debug Unit

This block watches the fetch stream of a processor for instruction breakpoints and turns a breakpoint hit, or an executed break instruction, into a debug exception entry. It holds a parameterized set of breakpoint address registers and one enable mask. Software loads these registers through a special-register write port. The same port also loads the processor status word, which this block owns.

On entry the block does five things. It records a cause code that names the event. It saves the program counter of the excepting instruction and the status word as it was before entry. It rewrites the status word to the configured debug level with exception mode set. It then emits a one-cycle redirect pulse, together with a target-selection value that tells the fetch unit which vector to take. Decode, the pipeline and the vector table belong to neighbouring blocks.

Top module: `ibreak_dbg_unit`

## Requirements
- R1: After reset, every output is zero: enable mask, status word, cause, saved PC, saved status and redirect.
- R2: A write to the enable register (select code 1) stores only bits [NUM_BP-1:0] of the write data. Every higher bit of `enable_out` reads zero.
- R3: A write to breakpoint address register `sr_idx` (select code 0) replaces its address whether or not that breakpoint is enabled. A later hit uses the new address.
- R4: A breakpoint hits only when `fetch_valid` is high, its enable bit is set and its address equals `fetch_pc` exactly. A disabled breakpoint causes no entry.
- R5: When several enabled breakpoints match, the cause field bits [7:4] carry the lowest matching index.
- R6: The cause is rewritten whole on each entry. Bit 0 marks a breakpoint hit, bit 1 a normal break (`brk_req` with `brk_narrow` low) and bit 2 a narrow break (`brk_narrow` high). All other bits are zero except the index field, which is set only for a hit.
- R7: On entry, `saved_pc` takes the `fetch_pc` of the excepting fetch.
- R8: On entry, `saved_status` takes the status word as it was before entry.
- R9: On entry, status bits [3:0] (interrupt level) become DEBUG_LEVEL and bit 4 (exception mode) is set. All other status bits stay unchanged.
- R10: While status bits [3:0] are at or above DEBUG_LEVEL, breakpoint hits are ignored. Break instructions still cause entry.
- R11: `redirect` is high for exactly the one cycle after the entry cycle, and `redirect_level` equals DEBUG_LEVEL.
- R12: A special-register write that arrives in the same cycle as an entry is dropped.
- R13: A breakpoint hit and a break instruction on the same fetch report only the breakpoint hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sr_we | input | 1 | Special-register write strobe |
| sr_sel | input | 2 | Write target: 0 breakpoint address, 1 enable mask, 2 status word |
| sr_idx | input | IDX_W | Breakpoint index for address writes |
| sr_wdata | input | AW | Write data |
| fetch_valid | input | 1 | Fetch PC is valid this cycle |
| fetch_pc | input | AW | Program counter of the fetched instruction |
| brk_req | input | 1 | Fetched instruction is a break instruction |
| brk_narrow | input | 1 | Break instruction is the narrow form |
| enable_out | output | EN_W | Enable mask readback |
| status_out | output | PSW | Processor status word |
| cause_out | output | 8 | Debug cause register |
| saved_pc | output | AW | PC saved at the debug level |
| saved_status | output | PSW | Status word saved at the debug level |
| redirect | output | 1 | One-cycle redirect pulse to the debug vector |
| redirect_level | output | 4 | Vector selection (debug level) |

## Verification
On every cycle, the assertions check several properties. The mask bits above the comparator count must read zero. An entry must leave the status word at the debug level with exception mode set and every other bit unchanged. The saved PC and saved status must match the previous cycle's fetch PC and status. Exactly one event bit must be set in the cause, and a suppressed level with no break request must produce no redirect.

Other behaviours are shown only by the bench's scenarios:
- choosing the lowest index among several matches,
- an address rewrite taking effect while the breakpoint is disabled,
- a register write being dropped on an entry cycle,
- a breakpoint taking precedence over a break,
- old cause bits being cleared.

// File: rtl/dbg_bp_pkg.sv
package dbg_bp_pkg;

    localparam int ILVL_LSB  = 0;
    localparam int ILVL_W    = 4;
    localparam int EXCM_BIT  = 4;
    localparam int CAUSE_W   = 8;

    typedef enum logic [1:0] {
        SR_BPADDR = 2'd0,
        SR_BPEN   = 2'd1,
        SR_STATUS = 2'd2
    } sr_sel_e;

    typedef struct packed {
        logic [3:0] bp_idx;
        logic       rsvd;
        logic       brk_n;
        logic       brk;
        logic       ibrk;
    } cause_t;

    function automatic cause_t build_cause(input logic bp_take, input logic [3:0] idx,
                                           input logic narrow);
        cause_t c;
        c = '0;
        if (bp_take) begin
            c.ibrk   = 1'b1;
            c.bp_idx = idx;
        end else if (narrow) begin
            c.brk_n = 1'b1;
        end else begin
            c.brk = 1'b1;
        end
        return c;
    endfunction

endpackage

// File: rtl/dbg_sr_file.sv
module dbg_sr_file
    import dbg_bp_pkg::*;
#(
    parameter int NUM_BP = 4,
    parameter int AW     = 32,
    parameter int IDX_W  = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [1:0]                  wr_sel,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [AW-1:0]               wr_data,
    output logic [NUM_BP-1:0][AW-1:0]   bp_addr,
    output logic [NUM_BP-1:0]           bp_en
);

    for (genvar g = 0; g < NUM_BP; g++) begin : g_addr
        always_ff @(posedge clk) begin
            if (rst) begin
                bp_addr[g] <= '0;
            end else if (wr_en && wr_sel == SR_BPADDR && int'(wr_idx) == g) begin
                bp_addr[g] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bp_en <= '0;
        end else if (wr_en && wr_sel == SR_BPEN) begin
            bp_en <= wr_data[NUM_BP-1:0];
        end
    end

endmodule

// File: rtl/dbg_bp_match.sv
module dbg_bp_match #(
    parameter int NUM_BP = 4,
    parameter int AW     = 32
) (
    input  logic [NUM_BP-1:0][AW-1:0] bp_addr,
    input  logic [NUM_BP-1:0]         bp_en,
    input  logic [AW-1:0]             pc,
    output logic                      hit,
    output logic [3:0]                hit_idx
);

    logic [NUM_BP-1:0] eq;

    for (genvar g = 0; g < NUM_BP; g++) begin : g_cmp
        assign eq[g] = bp_en[g] && (bp_addr[g] == pc);
    end

    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = NUM_BP - 1; i >= 0; i--) begin
            if (eq[i]) begin
                hit     = 1'b1;
                hit_idx = 4'(i);
            end
        end
    end

endmodule

// File: rtl/dbg_entry.sv
module dbg_entry
    import dbg_bp_pkg::*;
#(
    parameter int AW          = 32,
    parameter int PSW         = 16,
    parameter int DEBUG_LEVEL = 6
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           take,
    input  cause_t         cause_in,
    input  logic [AW-1:0]  pc,
    input  logic           st_we,
    input  logic [PSW-1:0] st_wdata,
    output logic [PSW-1:0] status,
    output cause_t         cause,
    output logic [AW-1:0]  saved_pc,
    output logic [PSW-1:0] saved_status,
    output logic           redirect
);

    function automatic logic [PSW-1:0] enter_status(input logic [PSW-1:0] s);
        logic [PSW-1:0] n;
        n = s;
        n[ILVL_LSB +: ILVL_W] = ILVL_W'(DEBUG_LEVEL);
        n[EXCM_BIT] = 1'b1;
        return n;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            status       <= '0;
            cause        <= '0;
            saved_pc     <= '0;
            saved_status <= '0;
            redirect     <= 1'b0;
        end else begin
            redirect <= take;
            if (take) begin
                cause        <= cause_in;
                saved_pc     <= pc;
                saved_status <= status;
                status       <= enter_status(status);
            end else if (st_we) begin
                status <= st_wdata;
            end
        end
    end

endmodule

// File: rtl/ibreak_dbg_unit.sv
module ibreak_dbg_unit
    import dbg_bp_pkg::*;
#(
    parameter int NUM_BP      = 4,
    parameter int AW          = 32,
    parameter int PSW         = 16,
    parameter int EN_W        = 8,
    parameter int DEBUG_LEVEL = 6,
    localparam int IDX_W      = (NUM_BP > 1) ? $clog2(NUM_BP) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sr_we,
    input  logic [1:0]          sr_sel,
    input  logic [IDX_W-1:0]    sr_idx,
    input  logic [AW-1:0]       sr_wdata,
    input  logic                fetch_valid,
    input  logic [AW-1:0]       fetch_pc,
    input  logic                brk_req,
    input  logic                brk_narrow,
    output logic [EN_W-1:0]     enable_out,
    output logic [PSW-1:0]      status_out,
    output logic [CAUSE_W-1:0]  cause_out,
    output logic [AW-1:0]       saved_pc,
    output logic [PSW-1:0]      saved_status,
    output logic                redirect,
    output logic [3:0]          redirect_level
);

    logic [NUM_BP-1:0][AW-1:0] bp_addr;
    logic [NUM_BP-1:0]         bp_en;
    logic                      bp_hit;
    logic [3:0]                bp_idx;
    logic                      suppress;
    logic                      bp_take;
    logic                      take;
    logic                      wr_ok;
    cause_t                    cause_nxt;
    cause_t                    cause_q;

    assign suppress  = status_out[ILVL_LSB +: ILVL_W] >= ILVL_W'(DEBUG_LEVEL);
    assign bp_take   = fetch_valid && bp_hit && !suppress;
    assign take      = bp_take || (fetch_valid && brk_req);
    assign wr_ok     = sr_we && !take;
    assign cause_nxt = build_cause(bp_take, bp_idx, brk_narrow);

    dbg_sr_file #(.NUM_BP(NUM_BP), .AW(AW), .IDX_W(IDX_W)) u_sr (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_ok),
        .wr_sel  (sr_sel),
        .wr_idx  (sr_idx),
        .wr_data (sr_wdata),
        .bp_addr (bp_addr),
        .bp_en   (bp_en)
    );

    dbg_bp_match #(.NUM_BP(NUM_BP), .AW(AW)) u_match (
        .bp_addr (bp_addr),
        .bp_en   (bp_en),
        .pc      (fetch_pc),
        .hit     (bp_hit),
        .hit_idx (bp_idx)
    );

    dbg_entry #(.AW(AW), .PSW(PSW), .DEBUG_LEVEL(DEBUG_LEVEL)) u_entry (
        .clk          (clk),
        .rst          (rst),
        .take         (take),
        .cause_in     (cause_nxt),
        .pc           (fetch_pc),
        .st_we        (wr_ok && sr_sel == SR_STATUS),
        .st_wdata     (sr_wdata[PSW-1:0]),
        .status       (status_out),
        .cause        (cause_q),
        .saved_pc     (saved_pc),
        .saved_status (saved_status),
        .redirect     (redirect)
    );

    assign enable_out     = EN_W'(bp_en);
    assign cause_out      = cause_q;
    assign redirect_level = 4'(DEBUG_LEVEL);

endmodule

// File: rtl/dbg_bp_checker.sv
module dbg_bp_checker
    import dbg_bp_pkg::*;
#(
    parameter int NUM_BP      = 4,
    parameter int AW          = 32,
    parameter int PSW         = 16,
    parameter int EN_W        = 8,
    parameter int DEBUG_LEVEL = 6
) (
    input logic                clk,
    input logic                rst,
    input logic                fetch_valid,
    input logic [AW-1:0]       fetch_pc,
    input logic                brk_req,
    input logic [EN_W-1:0]     enable_out,
    input logic [PSW-1:0]      status_out,
    input logic [CAUSE_W-1:0]  cause_out,
    input logic [AW-1:0]       saved_pc,
    input logic [PSW-1:0]      saved_status,
    input logic                redirect
);

    p_mask_high_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (enable_out >> NUM_BP) == '0);

    p_status_level_r9: assert property (@(posedge clk) disable iff (rst)
        redirect |-> (status_out[ILVL_LSB +: ILVL_W] == ILVL_W'(DEBUG_LEVEL)) && status_out[EXCM_BIT]);

    p_status_rest_r9: assert property (@(posedge clk) disable iff (rst)
        redirect |-> (status_out[PSW-1:EXCM_BIT+1] == $past(status_out[PSW-1:EXCM_BIT+1])));

    p_saved_pc_r7: assert property (@(posedge clk) disable iff (rst)
        redirect |-> saved_pc == $past(fetch_pc));

    p_saved_status_r8: assert property (@(posedge clk) disable iff (rst)
        redirect |-> saved_status == $past(status_out));

    p_cause_event_r6: assert property (@(posedge clk) disable iff (rst)
        redirect |-> $countones(cause_out[2:0]) == 1);

    p_suppress_r10: assert property (@(posedge clk) disable iff (rst)
        ((status_out[ILVL_LSB +: ILVL_W] >= ILVL_W'(DEBUG_LEVEL)) && !(fetch_valid && brk_req)) |=> !redirect);

endmodule

bind ibreak_dbg_unit dbg_bp_checker #(
    .NUM_BP(NUM_BP), .AW(AW), .PSW(PSW), .EN_W(EN_W), .DEBUG_LEVEL(DEBUG_LEVEL)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .fetch_valid  (fetch_valid),
    .fetch_pc     (fetch_pc),
    .brk_req      (brk_req),
    .enable_out   (enable_out),
    .status_out   (status_out),
    .cause_out    (cause_out),
    .saved_pc     (saved_pc),
    .saved_status (saved_status),
    .redirect     (redirect)
);

// File: tb/tb_ibreak_dbg_unit.sv
`timescale 1ns/1ps
module tb_ibreak_dbg_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sr_we = 1'b0;
    logic [1:0]  sr_sel = '0;
    logic [1:0]  sr_idx = '0;
    logic [31:0] sr_wdata = '0;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic        brk_req = 1'b0;
    logic        brk_narrow = 1'b0;
    logic [7:0]  enable_out;
    logic [15:0] status_out;
    logic [7:0]  cause_out;
    logic [31:0] saved_pc;
    logic [15:0] saved_status;
    logic        redirect;
    logic [3:0]  redirect_level;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    ibreak_dbg_unit dut (
        .clk(clk), .rst(rst), .sr_we(sr_we), .sr_sel(sr_sel), .sr_idx(sr_idx),
        .sr_wdata(sr_wdata), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
        .brk_req(brk_req), .brk_narrow(brk_narrow), .enable_out(enable_out),
        .status_out(status_out), .cause_out(cause_out), .saved_pc(saved_pc),
        .saved_status(saved_status), .redirect(redirect), .redirect_level(redirect_level)
    );

    typedef struct packed {
        logic        we;
        logic [1:0]  sel;
        logic [1:0]  idx;
        logic [31:0] wd;
        logic        fv;
        logic [31:0] pc;
        logic        brk;
        logic        nar;
        logic        exp_rd;
        logic [7:0]  exp_cause;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 2'd0, 2'd0, 32'h100, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0, 8'h00},
        '{1'b1, 2'd0, 2'd1, 32'h200, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0, 8'h00},
        '{1'b0, 2'd0, 2'd0, 32'h0,   1'b1, 32'h100, 1'b0, 1'b0, 1'b0, 8'h00},
        '{1'b1, 2'd1, 2'd0, 32'h3,   1'b0, 32'h0,   1'b0, 1'b0, 1'b0, 8'h00},
        '{1'b0, 2'd0, 2'd0, 32'h0,   1'b1, 32'h100, 1'b0, 1'b0, 1'b1, 8'h01},
        '{1'b1, 2'd2, 2'd0, 32'h0,   1'b0, 32'h0,   1'b0, 1'b0, 1'b0, 8'h01},
        '{1'b0, 2'd0, 2'd0, 32'h0,   1'b1, 32'h200, 1'b0, 1'b0, 1'b1, 8'h11},
        '{1'b1, 2'd2, 2'd0, 32'h0,   1'b0, 32'h0,   1'b0, 1'b0, 1'b0, 8'h11},
        '{1'b0, 2'd0, 2'd0, 32'h0,   1'b1, 32'h300, 1'b1, 1'b0, 1'b1, 8'h02},
        '{1'b1, 2'd2, 2'd0, 32'h0,   1'b0, 32'h0,   1'b0, 1'b0, 1'b0, 8'h02},
        '{1'b0, 2'd0, 2'd0, 32'h0,   1'b1, 32'h304, 1'b1, 1'b1, 1'b1, 8'h04},
        '{1'b1, 2'd2, 2'd0, 32'h0,   1'b0, 32'h0,   1'b0, 1'b0, 1'b0, 8'h04},
        '{1'b0, 2'd0, 2'd0, 32'h0,   1'b1, 32'h500, 1'b0, 1'b0, 1'b0, 8'h04}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input logic we, input logic [1:0] sel, input logic [1:0] idx,
                        input logic [31:0] wd, input logic fv, input logic [31:0] pc,
                        input logic brk, input logic nar);
        sr_we = we; sr_sel = sel; sr_idx = idx; sr_wdata = wd;
        fetch_valid = fv; fetch_pc = pc; brk_req = brk; brk_narrow = nar;
        @(negedge clk);
        sr_we = 1'b0; fetch_valid = 1'b0; brk_req = 1'b0; brk_narrow = 1'b0;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [1:0] idx, input logic [31:0] wd);
        step(1'b1, sel, idx, wd, 1'b0, 32'h0, 1'b0, 1'b0);
    endtask

    task automatic fetch(input logic [31:0] pc, input logic brk, input logic nar);
        step(1'b0, 2'd0, 2'd0, 32'h0, 1'b1, pc, brk, nar);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 enable", 64'(enable_out), 64'h0);
        chk("R1 status", 64'(status_out), 64'h0);
        chk("R1 cause", 64'(cause_out), 64'h0);
        chk("R1 saved_pc", 64'(saved_pc), 64'h0);
        chk("R1 saved_status", 64'(saved_status), 64'h0);
        chk("R1 redirect", 64'(redirect), 64'h0);

        // Table: R4 match/disabled, R6 cause encoding and clearing, R11 pulse
        for (int i = 0; i < NV; i++) begin
            step(VEC[i].we, VEC[i].sel, VEC[i].idx, VEC[i].wd, VEC[i].fv, VEC[i].pc,
                 VEC[i].brk, VEC[i].nar);
            chk("R4/R11 table redirect", 64'(redirect), 64'(VEC[i].exp_rd));
            chk("R6 table cause", 64'(cause_out), 64'(VEC[i].exp_cause));
        end

        // R2 enable masking
        wr(2'd1, 2'd0, 32'hFF);
        chk("R2 enable mask", 64'(enable_out), 64'h0F);

        // R5 lowest index among matches; R7 R9 R11
        wr(2'd0, 2'd2, 32'h700);
        wr(2'd0, 2'd3, 32'h700);
        fetch(32'h700, 1'b0, 1'b0);
        chk("R5 cause idx", 64'(cause_out), 64'h21);
        chk("R7 saved_pc", 64'(saved_pc), 64'h700);
        chk("R8 saved_status", 64'(saved_status), 64'h0);
        chk("R9 status", 64'(status_out), 64'h16);
        chk("R11 redirect", 64'(redirect), 64'h1);
        chk("R11 level", 64'(redirect_level), 64'h6);
        step(1'b0, 2'd0, 2'd0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0);
        chk("R11 pulse ends", 64'(redirect), 64'h0);

        // R10 suppression at debug level; break still enters
        fetch(32'h700, 1'b0, 1'b0);
        chk("R10 suppressed", 64'(redirect), 64'h0);
        chk("R10 cause kept", 64'(cause_out), 64'h21);
        fetch(32'h710, 1'b1, 1'b0);
        chk("R10 break enters", 64'(redirect), 64'h1);
        chk("R10 break cause", 64'(cause_out), 64'h02);
        chk("R7 break pc", 64'(saved_pc), 64'h710);
        chk("R8 nested status", 64'(saved_status), 64'h16);
        wr(2'd2, 2'd0, 32'h7);
        fetch(32'h700, 1'b0, 1'b0);
        chk("R10 above level", 64'(redirect), 64'h0);
        wr(2'd2, 2'd0, 32'h5);
        fetch(32'h700, 1'b0, 1'b0);
        chk("R10 below level", 64'(redirect), 64'h1);

        // R8 R9 other status bits preserved
        wr(2'd2, 2'd0, 32'hABC2);
        fetch(32'h100, 1'b0, 1'b0);
        chk("R6 hit cause", 64'(cause_out), 64'h01);
        chk("R8 saved_status", 64'(saved_status), 64'hABC2);
        chk("R9 status rewrite", 64'(status_out), 64'hABD6);

        // R12 write dropped on entry
        wr(2'd2, 2'd0, 32'h0);
        step(1'b1, 2'd2, 2'd0, 32'h5, 1'b1, 32'h200, 1'b0, 1'b0);
        chk("R12 status", 64'(status_out), 64'h16);
        chk("R12 saved_status", 64'(saved_status), 64'h0);
        chk("R12 cause", 64'(cause_out), 64'h11);

        // R13 breakpoint over break
        wr(2'd2, 2'd0, 32'h0);
        fetch(32'h200, 1'b1, 1'b1);
        chk("R13 cause", 64'(cause_out), 64'h11);

        // R3 address write while disabled
        wr(2'd2, 2'd0, 32'h0);
        wr(2'd1, 2'd0, 32'hE);
        wr(2'd0, 2'd0, 32'h900);
        fetch(32'h900, 1'b0, 1'b0);
        chk("R4 disabled no hit", 64'(redirect), 64'h0);
        wr(2'd1, 2'd0, 32'hF);
        fetch(32'h900, 1'b0, 1'b0);
        chk("R3 new address hit", 64'(redirect), 64'h1);
        chk("R3 cause", 64'(cause_out), 64'h01);
        wr(2'd2, 2'd0, 32'h0);
        fetch(32'h100, 1'b0, 1'b0);
        chk("R3 old address gone", 64'(redirect), 64'h0);

        finish_run();
    end

endmodule